// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the live calendar fields of a time-keeping core (minute, hour, day of month and day of week, all in BCD) and compares them with four programmed alarm values. Each alarm value has its own disable bit, and a field takes part in the comparison only while that bit is 0. When every participating field equals its live counterpart, the block raises a sticky alarm flag. It raises the flag once, on the clock where the match begins. A match that persists does not raise it again after a clear.

The flag stays up until the host performs a flag-clear write carrying a 0 in the flag position. A write carrying a 1 leaves the flag as it is, so a control word that clears other flags does not disturb this one. An interrupt-enable input gates the flag onto the interrupt request. The hour comparison covers the whole hour field, including the AM/PM bit used in 12-hour mode.

Top module: `alarm_match_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `alarm_flag` and `alarm_irq` are 0.
- R2: A field whose disable bit is 0 takes part in the comparison. If any participating field differs from its live value, the flag does not rise.
- R3: A field whose disable bit is 1 is ignored. Its alarm value may differ from the live value and the flag still rises when the other participating fields match.
- R4: When all four disable bits are 1, the flag never rises, even if every value matches.
- R5: The flag is 1 on the first clock edge at which the full match becomes true. While the match continues unbroken, it is not set again after a clear.
- R6: Once set, the flag holds until a flag-clear write (`clr_wr`=1) with `clr_data`=0. A flag-clear write with `clr_data`=1 leaves the flag at 1.
- R7: `alarm_irq` equals `alarm_flag` when `irq_en`=1, and is 0 when `irq_en`=0. It follows `irq_en` in the same cycle.
- R8: The hour comparison includes bit 5 of the hour field (the PM bit in 12-hour mode). An alarm at 6'h21 does not match a live hour of 6'h01.
- R9: When a match begins on the same edge as a clearing write, the flag ends up 1, with the default `SET_WINS`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_min | input | MIN_W | Live minutes, BCD |
| cur_hour | input | HOUR_W | Live hours, BCD, bit 5 is PM in 12-hour mode |
| cur_day | input | DAY_W | Live day of month, BCD |
| cur_wday | input | WDAY_W | Live day of week |
| alm_min | input | MIN_W | Minute alarm value |
| alm_min_off | input | 1 | 1 removes the minute field from the comparison |
| alm_hour | input | HOUR_W | Hour alarm value, including the PM bit |
| alm_hour_off | input | 1 | 1 removes the hour field |
| alm_day | input | DAY_W | Day alarm value |
| alm_day_off | input | 1 | 1 removes the day field |
| alm_wday | input | WDAY_W | Weekday alarm value |
| alm_wday_off | input | 1 | 1 removes the weekday field |
| irq_en | input | 1 | Lets the alarm flag drive the interrupt request |
| clr_wr | input | 1 | Host flag-clear write strobe |
| clr_data | input | 1 | Value written to the flag position: 0 clears, 1 keeps |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request from the alarm |

## Verification
Two events can land on the same clock edge: the start of a match, which sets the flag, and a host clearing write, which resets it. The bench first sets the flag and then breaks the match for one cycle. In a single cycle it then restores the match and issues a write with a 0. It judges the outcome by reading `alarm_flag` after that edge, where it expects 1. A later clear while the match is still held must then leave the flag at 0, which shows that the rise was consumed once.

// File: rtl/alm_pkg.sv
package alm_pkg;

  localparam int NUM_FIELDS = 4;

  // field slots in the packed comparison vectors
  localparam int SLOT_MIN  = 0;
  localparam int SLOT_HOUR = 1;
  localparam int SLOT_DAY  = 2;
  localparam int SLOT_WDAY = 3;

  // a full match needs at least one participating field and no participating miss
  function automatic logic all_fields_match(input logic [NUM_FIELDS-1:0] part,
                                            input logic [NUM_FIELDS-1:0] hit);
    return (|part) && (&(hit | ~part));
  endfunction

  // next flag value; set_first picks which of set and clear has priority
  function automatic logic next_flag(input logic cur, input logic set_ev,
                                     input logic clr_ev, input logic set_first);
    if (set_first)
      return set_ev ? 1'b1 : (clr_ev ? 1'b0 : cur);
    else
      return clr_ev ? 1'b0 : (set_ev ? 1'b1 : cur);
  endfunction

endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] cur_val,
  input  logic [W-1:0] alm_val,
  input  logic         off,
  output logic         part,
  output logic         hit
);
  // a field participates while its disable bit is low
  assign part = ~off;
  assign hit  = (cur_val == alm_val);
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match_all,
  input  logic clr_req,
  output logic match_rise,
  output logic flag
);
  import alm_pkg::*;

  logic match_q;
  logic flag_q;
  logic flag_d;

  assign match_rise = match_all & ~match_q;

  generate
    if (SET_WINS) begin : g_set_first
      always_comb flag_d = next_flag(flag_q, match_rise, clr_req, 1'b1);
    end else begin : g_clr_first
      always_comb flag_d = next_flag(flag_q, match_rise, clr_req, 1'b0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= match_all;
      flag_q  <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int MIN_W    = 7,
  parameter int HOUR_W   = 6,
  parameter int DAY_W    = 6,
  parameter int WDAY_W   = 3,
  parameter bit SET_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic              alm_min_off,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic              alm_hour_off,
  input  logic [DAY_W-1:0]  alm_day,
  input  logic              alm_day_off,
  input  logic [WDAY_W-1:0] alm_wday,
  input  logic              alm_wday_off,
  input  logic              irq_en,
  input  logic              clr_wr,
  input  logic              clr_data,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  import alm_pkg::*;

  localparam int W01 = (MIN_W > HOUR_W) ? MIN_W : HOUR_W;
  localparam int W23 = (DAY_W > WDAY_W) ? DAY_W : WDAY_W;
  localparam int FW  = (W01 > W23) ? W01 : W23;

  logic [NUM_FIELDS-1:0][FW-1:0] cur_v;
  logic [NUM_FIELDS-1:0][FW-1:0] alm_v;
  logic [NUM_FIELDS-1:0]         off_v;
  logic [NUM_FIELDS-1:0]         part_v;
  logic [NUM_FIELDS-1:0]         hit_v;

  // named internal events, observed by the bound checker
  logic match_all;
  logic match_rise;
  logic clr_req;
  logic all_off;

  assign cur_v[SLOT_MIN]  = FW'(cur_min);
  assign cur_v[SLOT_HOUR] = FW'(cur_hour);
  assign cur_v[SLOT_DAY]  = FW'(cur_day);
  assign cur_v[SLOT_WDAY] = FW'(cur_wday);
  assign alm_v[SLOT_MIN]  = FW'(alm_min);
  assign alm_v[SLOT_HOUR] = FW'(alm_hour);
  assign alm_v[SLOT_DAY]  = FW'(alm_day);
  assign alm_v[SLOT_WDAY] = FW'(alm_wday);
  assign off_v = {alm_wday_off, alm_day_off, alm_hour_off, alm_min_off};

  generate
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      alm_field_cmp #(.W(FW)) u_cmp (
        .cur_val (cur_v[i]),
        .alm_val (alm_v[i]),
        .off     (off_v[i]),
        .part    (part_v[i]),
        .hit     (hit_v[i])
      );
    end
  endgenerate

  assign match_all = all_fields_match(part_v, hit_v);
  assign all_off   = &off_v;
  assign clr_req   = clr_wr & ~clr_data;

  alm_flag_ctl #(.SET_WINS(SET_WINS)) u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_all  (match_all),
    .clr_req    (clr_req),
    .match_rise (match_rise),
    .flag       (alarm_flag)
  );

  assign alarm_irq = alarm_flag & irq_en;
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic match_all,
  input logic match_rise,
  input logic clr_req,
  input logic all_off,
  input logic irq_en,
  input logic alarm_flag,
  input logic alarm_irq
);
  AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !alarm_irq);                                            // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_flag);                                          // R7
  AST_ALL_OFF_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> !match_all);                                            // R4
  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (match_rise && !clr_req) |=> alarm_flag);                           // R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !match_rise) |=> !alarm_flag);                      // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_req) |=> alarm_flag);                           // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match_rise) |=> !alarm_flag);                          // R6
endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .match_all  (match_all),
  .match_rise (match_rise),
  .clr_req    (clr_req),
  .all_off    (all_off),
  .irq_en     (irq_en),
  .alarm_flag (alarm_flag),
  .alarm_irq  (alarm_irq)
);

// File: tb/alarm_match_unit_test.sv
`timescale 1ns/1ps
module alarm_match_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cmin = '0, amin = '0;
  logic [5:0] chour = '0, ahour = '0, cday = '0, aday = '0;
  logic [2:0] cwday = '0, awday = '0;
  logic [3:0] aoff = 4'hF;   // bit0 minute, bit1 hour, bit2 day, bit3 weekday
  logic       irq_en = 1'b0, clr_wr = 1'b0, clr_data = 1'b1;
  logic       flag, irq;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  alarm_match_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cur_min(cmin), .cur_hour(chour), .cur_day(cday), .cur_wday(cwday),
    .alm_min(amin), .alm_min_off(aoff[0]),
    .alm_hour(ahour), .alm_hour_off(aoff[1]),
    .alm_day(aday), .alm_day_off(aoff[2]),
    .alm_wday(awday), .alm_wday_off(aoff[3]),
    .irq_en(irq_en), .clr_wr(clr_wr), .clr_data(clr_data),
    .alarm_flag(flag), .alarm_irq(irq)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // all fields disabled and flag cleared; leaves no pending match
  task automatic idle();
    aoff = 4'hF; clr_wr = 1'b1; clr_data = 1'b0;
    step();
    clr_wr = 1'b0; clr_data = 1'b1;
    step();
  endtask

  task automatic t_reset();
    check(flag, 1'b0, "R1 flag in reset");
    check(irq, 1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    step();
    check(flag, 1'b0, "R1 flag after reset");
  endtask

  task automatic t_single_field();
    idle();
    amin = 7'h30; cmin = 7'h29; aoff = 4'b1110;
    step();
    check(flag, 1'b0, "R2 minute mismatch");
    cmin = 7'h30;
    step();
    check(flag, 1'b1, "R2 minute match sets flag");
  endtask

  task automatic t_all_fields();
    idle();
    amin = 7'h45; ahour = 6'h07; aday = 6'h12; awday = 3'd3;
    cmin = 7'h45; chour = 6'h07; cday = 6'h12; cwday = 3'd2;
    aoff = 4'b0000;
    step();
    check(flag, 1'b0, "R2 weekday differs");
    cwday = 3'd3;
    step();
    check(flag, 1'b1, "R2 all four match");
  endtask

  task automatic t_disabled_field();
    idle();
    amin = 7'h10; cmin = 7'h59; aday = 6'h01; cday = 6'h28;
    ahour = 6'h15; chour = 6'h15; awday = 3'd5; cwday = 3'd5;
    aoff = 4'b0101;
    step();
    check(flag, 1'b1, "R3 disabled minute and day ignored");
  endtask

  task automatic t_all_off();
    idle();
    amin = 7'h00; cmin = 7'h00; ahour = 6'h00; chour = 6'h00;
    aday = 6'h01; cday = 6'h01; awday = 3'd0; cwday = 3'd0;
    aoff = 4'hF;
    step(); step(); step();
    check(flag, 1'b0, "R4 all disabled never sets");
  endtask

  task automatic t_hold_once();
    idle();
    amin = 7'h05; cmin = 7'h05; aoff = 4'b1110;
    step();
    check(flag, 1'b1, "R5 set on first match edge");
    step(); step();
    check(flag, 1'b1, "R6 flag held without clear");
    clr_wr = 1'b1; clr_data = 1'b0;
    step();
    clr_wr = 1'b0; clr_data = 1'b1;
    check(flag, 1'b0, "R6 clear write drops flag");
    step(); step(); step();
    check(flag, 1'b0, "R5 held match does not set again");
  endtask

  task automatic t_write_one();
    idle();
    amin = 7'h22; cmin = 7'h22; aoff = 4'b1110;
    step();
    clr_wr = 1'b1; clr_data = 1'b1;
    step();
    clr_wr = 1'b0;
    check(flag, 1'b1, "R6 write of 1 keeps flag");
    clr_wr = 1'b1; clr_data = 1'b0;
    step();
    clr_wr = 1'b0; clr_data = 1'b1;
    check(flag, 1'b0, "R6 write of 0 clears flag");
  endtask

  task automatic t_irq();
    idle();
    irq_en = 1'b1;
    #0.5;
    check(irq, 1'b0, "R7 no irq without flag");
    irq_en = 1'b0;
    amin = 7'h33; cmin = 7'h33; aoff = 4'b1110;
    step();
    check(irq, 1'b0, "R7 irq masked");
    irq_en = 1'b1;
    #0.5;
    check(irq, 1'b1, "R7 irq follows flag");
    irq_en = 1'b0;
    step();
  endtask

  task automatic t_pm_bit();
    idle();
    ahour = 6'h21; chour = 6'h01; aoff = 4'b1101;
    step();
    check(flag, 1'b0, "R8 AM hour misses PM alarm");
    chour = 6'h21;
    step();
    check(flag, 1'b1, "R8 PM hour matches");
  endtask

  task automatic t_collision();
    idle();
    amin = 7'h40; cmin = 7'h40; aoff = 4'b1110;
    step();
    cmin = 7'h41;
    step();
    check(flag, 1'b1, "R9 flag up before collision");
    cmin = 7'h40; clr_wr = 1'b1; clr_data = 1'b0;
    step();
    clr_wr = 1'b0; clr_data = 1'b1;
    check(flag, 1'b1, "R9 set beats clear on same edge");
    clr_wr = 1'b1; clr_data = 1'b0;
    step();
    clr_wr = 1'b0; clr_data = 1'b1;
    check(flag, 1'b0, "R9 later clear under held match");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single_field();
    t_all_fields();
    t_disabled_field();
    t_all_off();
    t_hold_once();
    t_write_one();
    t_irq();
    t_pm_bit();
    t_collision();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule